// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block pairs a volatile word array with a nonvolatile backup array of the same size. It moves data between the two. Both arrays are modelled as synchronous register memories. When no transfer runs, an external port reads and writes the volatile array like an ordinary SRAM. A command detector upstream issues single-cycle store and recall requests. A store first erases the backup array and then programs it with a copy of the volatile array. A recall first clears the volatile array and then fills it from the backup, which it leaves untouched.

Two digital supply flags come from an analog monitor: `sup_ok` means the supply is above the switch level, and `below_rst` means it has fallen under the reset level. A drop under the reset level, and every reset of the block, arms an automatic restore. That restore starts as soon as the supply is back above the switch level. While any transfer runs, the block raises `busy`, ignores the external port and holds its output enable low. The length of each operation is a cycle-count parameter, so the same RTL serves long real timings and short test timings. Each duration must be at least twice the array depth.

Top module: `nvs_ctrl`

## Requirements
- R1: While idle, `ext_en`=1 with `ext_we`=0 drives `ext_oe`=1 and puts the word at `ext_addr` on `ext_rdata` in the same cycle. Otherwise `ext_oe`=0 and `ext_rdata`=0.
- R2: While idle, `ext_en`=1 with `ext_we`=1 writes `ext_wdata` to `ext_addr` at the clock edge.
- R3: While `busy`=1, external writes are ignored, `ext_oe` stays 0 and `ext_rdata` stays 0.
- R4: A store erases the backup array to all ones and then programs it with the volatile contents held at the start edge. A later recall returns exactly those words.
- R5: A recall clears the volatile array and then copies the backup into it. The backup is not changed, so repeated recalls give the same contents.
- R6: `busy` rises in the cycle after the accepting edge. It stays high for exactly STORE_CYC, RECALL_CYC or RESTORE_CYC cycles, according to the operation.
- R7: `done` is high for exactly one cycle, the first cycle after `busy` falls.
- R8: Reset and every cycle with `below_rst`=1 arm a pending restore. When the block is idle, a restore is pending and `sup_ok`=1, a restore of RESTORE_CYC cycles starts at the next edge.
- R9: A dip with `sup_ok`=0 but `below_rst`=0 arms no restore, so no transfer starts when `sup_ok` returns.
- R10: A store request is rejected while `sup_ok`=0. The backup keeps its old contents.
- R11: Requests that arrive while `busy`=1 are dropped and do not start a later transfer.
- R12: A pending restore takes priority: while it waits, software requests are dropped. A store request that arrives in the same cycle as a recall request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sup_ok | input | 1 | Supply above switch level |
| below_rst | input | 1 | Supply below reset level |
| store_req | input | 1 | Store request from command detector |
| recall_req | input | 1 | Recall request from command detector |
| ext_en | input | 1 | External access enable |
| ext_we | input | 1 | External write (1) or read (0) |
| ext_addr | input | AW | External word address |
| ext_wdata | input | DW | External write data |
| ext_rdata | output | DW | Read data, zero when not driving |
| ext_oe | output | 1 | Read data valid / output enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A wrong phase or address walk inside a transfer stays hidden until the volatile array is read back. A faulty store shows only after a later recall, when the words that come back differ at the first read. A mistake in the cycle counter or in the restore latch shows at once on the port: `busy` rises or falls one or more cycles off, or never rises after `sup_ok` returns. A missing gate on the external port shows as `ext_oe` high or as a corrupted word during a transfer. The bench therefore compares the busy, done and read outputs with its model on every cycle. It reads back the whole array after each operation.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    OP_STORE   = 2'd0,
    OP_RECALL  = 2'd1,
    OP_RESTORE = 2'd2
  } nvs_op_e;
endpackage

// File: rtl/nvs_rst_sync.sv
module nvs_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_out_n = sync_q[1];
endmodule

// File: rtl/nvs_regmem.sv
module nvs_regmem #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= '0;
      end
    end else if (wr_en) begin
      cells[wr_addr] <= wr_data;
    end
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq
  import nvs_pkg::*;
#(
  parameter int AW          = 9,
  parameter int STORE_CYC   = 1000000,
  parameter int RECALL_CYC  = 2000,
  parameter int RESTORE_CYC = 55000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          store_req,
  input  logic          recall_req,
  input  logic          sup_ok,
  input  logic          below_rst,
  output logic          busy,
  output logic          done,
  output logic          por_pend,
  output nvs_op_e       op,
  output logic          ph_first,
  output logic          ph_second,
  output logic [AW-1:0] xfer_addr
);
  localparam int DEPTH = 1 << AW;
  localparam int MAX_SR = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAXD = (MAX_SR > RESTORE_CYC) ? MAX_SR : RESTORE_CYC;
  localparam int CW = $clog2(MAXD + 1);
  localparam logic [CW-1:0] ST_LAST = CW'(STORE_CYC - 1);
  localparam logic [CW-1:0] RC_LAST = CW'(RECALL_CYC - 1);
  localparam logic [CW-1:0] RS_LAST = CW'(RESTORE_CYC - 1);
  localparam logic [CW-1:0] ONE_SPAN = CW'(DEPTH);
  localparam logic [CW-1:0] TWO_SPAN = CW'(2 * DEPTH);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          por_q, por_d;
  nvs_op_e       op_q, op_d;
  logic          op_en;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [CW-1:0] last_cnt;

  always_comb begin
    unique case (op_q)
      OP_STORE:  last_cnt = ST_LAST;
      OP_RECALL: last_cnt = RC_LAST;
      default:   last_cnt = RS_LAST;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    por_d  = por_q;
    op_d   = op_q;
    op_en  = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (busy_q) begin
      cnt_en = 1'b1;
      if (cnt_q == last_cnt) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else if (por_q) begin
      if (sup_ok) begin
        busy_d = 1'b1;
        por_d  = 1'b0;
        op_d   = OP_RESTORE;
        op_en  = 1'b1;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
    end else if (store_req) begin
      if (sup_ok) begin
        busy_d = 1'b1;
        op_d   = OP_STORE;
        op_en  = 1'b1;
        cnt_d  = '0;
        cnt_en = 1'b1;
      end
    end else if (recall_req) begin
      busy_d = 1'b1;
      op_d   = OP_RECALL;
      op_en  = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end
    if (below_rst) begin
      por_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      por_q  <= 1'b1;
      op_q   <= OP_STORE;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      por_q  <= por_d;
      if (op_en) begin
        op_q <= op_d;
      end
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign por_pend  = por_q;
  assign op        = op_q;
  assign ph_first  = busy_q && (cnt_q < ONE_SPAN);
  assign ph_second = busy_q && (cnt_q >= ONE_SPAN) && (cnt_q < TWO_SPAN);
  assign xfer_addr = cnt_q[AW-1:0];
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int AW          = 9,
  parameter int DW          = 8,
  parameter int STORE_CYC   = 1000000,
  parameter int RECALL_CYC  = 2000,
  parameter int RESTORE_CYC = 55000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sup_ok,
  input  logic          below_rst,
  input  logic          store_req,
  input  logic          recall_req,
  input  logic          ext_en,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  output logic [DW-1:0] ext_rdata,
  output logic          ext_oe,
  output logic          busy,
  output logic          done
);
  localparam logic [DW-1:0] ERASED_WORD = {DW{1'b1}};

  logic          rst_sync_n;
  logic          por_pend;
  nvs_op_e       op;
  logic          ph_first, ph_second;
  logic [AW-1:0] xfer_addr;
  logic          is_store;

  logic          v_we;
  logic [AW-1:0] v_waddr, v_raddr;
  logic [DW-1:0] v_wdata, v_rdata;
  logic          s_we;
  logic [DW-1:0] s_wdata, s_rdata;

  nvs_rst_sync u_rst (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  nvs_seq #(
    .AW          (AW),
    .STORE_CYC   (STORE_CYC),
    .RECALL_CYC  (RECALL_CYC),
    .RESTORE_CYC (RESTORE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .store_req  (store_req),
    .recall_req (recall_req),
    .sup_ok     (sup_ok),
    .below_rst  (below_rst),
    .busy       (busy),
    .done       (done),
    .por_pend   (por_pend),
    .op         (op),
    .ph_first   (ph_first),
    .ph_second  (ph_second),
    .xfer_addr  (xfer_addr)
  );

  assign is_store = (op == OP_STORE);

  always_comb begin
    v_we    = 1'b0;
    v_waddr = ext_addr;
    v_wdata = ext_wdata;
    s_we    = 1'b0;
    s_wdata = ERASED_WORD;
    if (busy) begin
      if (is_store) begin
        s_we    = ph_first | ph_second;
        s_wdata = ph_second ? v_rdata : ERASED_WORD;
      end else begin
        v_we    = ph_first | ph_second;
        v_waddr = xfer_addr;
        v_wdata = ph_second ? s_rdata : '0;
      end
    end else begin
      v_we = ext_en & ext_we;
    end
  end

  assign v_raddr = busy ? xfer_addr : ext_addr;

  nvs_regmem #(.AW(AW), .DW(DW)) u_vol (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (v_we),
    .wr_addr (v_waddr),
    .wr_data (v_wdata),
    .rd_addr (v_raddr),
    .rd_data (v_rdata)
  );

  nvs_regmem #(.AW(AW), .DW(DW)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (s_we),
    .wr_addr (xfer_addr),
    .wr_data (s_wdata),
    .rd_addr (xfer_addr),
    .rd_data (s_rdata)
  );

  assign ext_oe    = ext_en & ~ext_we & ~busy;
  assign ext_rdata = ext_oe ? v_rdata : '0;
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk #(
  parameter int STORE_CYC   = 1000000,
  parameter int RECALL_CYC  = 2000,
  parameter int RESTORE_CYC = 55000
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic ext_oe,
  input logic store_req,
  input logic sup_ok,
  input logic por_pend
);
  localparam int MAX_SR = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAXD = (MAX_SR > RESTORE_CYC) ? MAX_SR : RESTORE_CYC;

  logic [31:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else begin
      run_cnt <= busy ? run_cnt + 32'd1 : 32'd0;
    end
  end

  AST_NO_OE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ext_oe); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 32'(MAXD)); // R6
  AST_RESTORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && por_pend && sup_ok) |=> busy); // R8
  AST_LOWSUP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !por_pend && store_req && !sup_ok) |=> !busy); // R10
  AST_PEND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && por_pend && !sup_ok) |=> !busy); // R12
endmodule

bind nvs_ctrl nvs_ctrl_chk #(
  .STORE_CYC   (STORE_CYC),
  .RECALL_CYC  (RECALL_CYC),
  .RESTORE_CYC (RESTORE_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .busy      (busy),
  .done      (done),
  .ext_oe    (ext_oe),
  .store_req (store_req),
  .sup_ok    (sup_ok),
  .por_pend  (por_pend)
);

// File: tb/tb_nvs_ctrl.sv
module tb_nvs_ctrl;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int ST = 40;
  localparam int RC = 36;
  localparam int RS = 50;

  logic clk = 1'b0;
  logic rst_n;
  logic sok, brst, st, rc, en, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic oe, busy, done;

  int total = 0;
  int bad = 0;

  int  mvol [DEPTH];
  int  msh  [DEPTH];
  bit  mbusy, mdone, mpor;
  int  mrem;

  always #5 clk = ~clk;

  nvs_ctrl #(
    .AW(AW), .DW(DW), .STORE_CYC(ST), .RECALL_CYC(RC), .RESTORE_CYC(RS)
  ) dut (
    .clk(clk), .rst_n(rst_n), .sup_ok(sok), .below_rst(brst),
    .store_req(st), .recall_req(rc), .ext_en(en), .ext_we(we),
    .ext_addr(addr), .ext_wdata(wdata), .ext_rdata(rdata), .ext_oe(oe),
    .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: transfers applied whole at the start edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mbusy = 0; mdone = 0; mpor = 1; mrem = 0;
      for (int i = 0; i < DEPTH; i++) begin mvol[i] = 0; msh[i] = 0; end
    end else begin
      mdone = 0;
      if (mbusy) begin
        mrem--;
        if (mrem == 0) begin mbusy = 0; mdone = 1; end
      end else begin
        if (en && we) mvol[addr] = wdata;
        if (mpor) begin
          if (sok) begin mbusy = 1; mrem = RS; mpor = 0; mvol = msh; end
        end else if (st) begin
          if (sok) begin mbusy = 1; mrem = ST; msh = mvol; end
        end else if (rc) begin
          mbusy = 1; mrem = RC; mvol = msh;
        end
      end
      if (brst) mpor = 1;
    end
  end

  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      bit exp_oe;
      exp_oe = !mbusy && en && !we;
      chk("R6 busy vs model", int'(busy), int'(mbusy));
      chk("R7 done vs model", int'(done), int'(mdone));
      chk(mbusy ? "R3 oe during transfer" : "R1 oe", int'(oe), int'(exp_oe));
      chk(exp_oe ? "R1 read data" : "R3 idle data", int'(rdata), exp_oe ? mvol[addr] : 0);
    end
  end

  task automatic idle_in();
    en = 0; we = 0; st = 0; rc = 0; wdata = '0;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    idle_in(); en = 1; we = 1; addr = AW'(a); wdata = DW'(d);
  endtask

  task automatic rd(input int a, input int exp, input string tag);
    @(negedge clk);
    idle_in(); en = 1; addr = AW'(a);
    #2;
    chk(tag, int'(rdata), exp);
  endtask

  task automatic hold(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      idle_in();
    end
  endtask

  task automatic run_op(input int dur_exp, input string tag, input bit disturb);
    int n;
    bit seen;
    n = 0; seen = 0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      if (busy) begin
        n++; seen = 1;
        idle_in();
        if (disturb) begin
          en = 1; we = k[0]; addr = AW'(k); wdata = 8'h55; st = 1; rc = 1;
        end
      end else if (seen) begin
        idle_in();
        #2;
        chk("R7 done after transfer", int'(done), 1);
        break;
      end else begin
        idle_in();
      end
    end
    chk(tag, n, dur_exp);
  endtask

  function automatic int pat(input int a, input int s);
    return (a * 7 + s) & 8'hFF;
  endfunction

  initial begin
    #(10 * 20000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; sok = 0; brst = 0; addr = '0; idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #2;
    chk("R6 reset busy low", int'(busy), 0);
    chk("R7 reset done low", int'(done), 0);
    hold(3);
    chk("R8 no restore while supply low", int'(busy), 0);
    @(negedge clk); sok = 1;
    run_op(RS, "R8 power-up restore length", 0);
    for (int a = 0; a < DEPTH; a++) rd(a, 0, "R8 restore of blank backup");

    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 3));
    for (int a = 0; a < DEPTH; a++) rd(a, pat(a, 3), "R2 write then read");

    @(negedge clk); idle_in(); st = 1;
    run_op(ST, "R6 store length", 1);
    hold(4);
    chk("R11 requests during store dropped", int'(busy), 0);
    for (int a = 0; a < DEPTH; a++) rd(a, pat(a, 3), "R3 writes during store ignored");

    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 11));
    @(negedge clk); idle_in(); rc = 1;
    run_op(RC, "R6 recall length", 0);
    for (int a = 0; a < DEPTH; a++) rd(a, pat(a, 3), "R4 recall returns stored words");
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 19));
    @(negedge clk); idle_in(); rc = 1;
    run_op(RC, "R5 second recall length", 0);
    for (int a = 0; a < DEPTH; a++) rd(a, pat(a, 3), "R5 backup unchanged by recall");

    @(negedge clk); sok = 0;
    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 29));
    @(negedge clk); idle_in(); st = 1;
    @(negedge clk); idle_in(); #2;
    chk("R10 store rejected at low supply", int'(busy), 0);
    hold(3);
    @(negedge clk); sok = 1;
    hold(5);
    chk("R9 dip above reset level starts nothing", int'(busy), 0);
    @(negedge clk); idle_in(); rc = 1;
    run_op(RC, "R5 recall length", 0);
    for (int a = 0; a < DEPTH; a++) rd(a, pat(a, 3), "R10 backup kept after rejected store");

    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 41));
    @(negedge clk); idle_in(); sok = 0; brst = 1;
    hold(2);
    @(negedge clk); brst = 0;
    @(negedge clk); idle_in(); rc = 1;
    @(negedge clk); idle_in(); st = 1;
    @(negedge clk); idle_in(); #2;
    chk("R12 software requests dropped while restore pending", int'(busy), 0);
    @(negedge clk); sok = 1;
    run_op(RS, "R8 restore after brown-out", 0);
    for (int a = 0; a < DEPTH; a++) rd(a, pat(a, 3), "R8 restore brings back backup");

    for (int a = 0; a < DEPTH; a++) wr(a, pat(a, 53));
    @(negedge clk); idle_in(); st = 1; rc = 1;
    run_op(ST, "R12 store wins over recall", 0);
    for (int a = 0; a < DEPTH; a++) wr(a, 0);
    @(negedge clk); idle_in(); rc = 1;
    run_op(RC, "R5 recall length final", 0);
    for (int a = 0; a < DEPTH; a++) rd(a, pat(a, 53), "R4 second store captured");

    hold(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule